// File: doc/BRIEF.md
# Configurable Asynchronous Serial Receiver

This block turns a single NRZ serial line back into characters. The line rests high. A frame begins when the line falls into a low start bit. The receiver counts a one-cycle oversampling tick, which arrives sixteen times per bit, and samples the line once near the middle of each bit. The data bits follow the start bit, then an optional parity bit, then one or two stop bits.

Configuration inputs set the character length (5 to 8 bits), the order in which data bits arrive, whether a parity bit is present and whether it is even or odd, and how many stop bits are expected. The character is placed right-justified in an 8-bit result and the unused upper bits are zero. The result is announced by a one-cycle valid pulse, together with a parity-error flag and a framing-error flag. The result and both flags stay unchanged until the next valid pulse.

The serial input passes through a two-flop synchronizer before the falling edge is detected. A start bit that is back high at its mid-bit sample is treated as a glitch and discarded. Baud tick generation, buffering and overrun handling are supplied by the surrounding logic.

Top module: `serial_frame_rx`

## Requirements
- R1: While `rst_n` is low at a clock edge, the following edge leaves `rx_valid`, `rx_data`, `rx_par_err` and `rx_frm_err` at zero, and any frame in progress is abandoned.
- R2: A frame starts only on a high-to-low transition of the synchronized line. If the line is high again at the start bit's mid-point sample (8 ticks after the edge), the receiver returns to idle and produces no valid pulse.
- R3: `cfg_len` selects the character length: 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8. The character is right-justified in `rx_data` and every bit above the character is 0.
- R4: With `cfg_msb_first` = 0 the first data bit received goes to bit 0. With `cfg_msb_first` = 1 the first data bit received goes to bit (length-1).
- R5: With `cfg_par_en` = 1 one parity bit follows the data. In even mode (`cfg_par_odd` = 0) the parity bit equals the XOR of the data bits. In odd mode it equals the inverse of that XOR. `rx_par_err` is 1 exactly when the received parity bit differs from that value.
- R6: With `cfg_par_en` = 0 no parity bit is expected: the stop bits follow the last data bit directly, and `rx_par_err` is 0.
- R7: `cfg_two_stop` selects 1 stop bit (0) or 2 stop bits (1). `rx_frm_err` is 1 when any expected stop bit is sampled low.
- R8: `rx_valid` is high for exactly one clock per received frame, at the sample of the last expected stop bit. `rx_data` and both flags change only alongside `rx_valid` and hold their values in between.
- R9: If the line stays low after a frame whose stop bit was low, no further frame is received until the line has returned high and then fallen again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| os_tick | input | 1 | Oversampling tick, one cycle wide, 16 per bit |
| rxd_in | input | 1 | Asynchronous serial line, idle high |
| cfg_len | input | 2 | Character length code (0..3 gives 5..8 bits) |
| cfg_two_stop | input | 1 | 1 expects two stop bits |
| cfg_par_en | input | 1 | 1 expects a parity bit |
| cfg_par_odd | input | 1 | 1 selects odd parity, 0 selects even |
| cfg_msb_first | input | 1 | 1 means the first data bit is the MSB |
| rx_data | output | 8 | Received character, right-justified |
| rx_valid | output | 1 | One-cycle pulse when a character is complete |
| rx_par_err | output | 1 | Parity mismatch for the reported character |
| rx_frm_err | output | 1 | A stop bit was sampled low |

## Verification
A parity mismatch and a low stop bit can both be reported on the same valid pulse. The bench provokes this with a frame that carries an inverted parity bit and also drives its stop bit low. It then checks that both flags are set together with the correct character. The same stop-bit failure is repeated with the line left low afterwards. Only one valid pulse may appear, and the next frame is accepted only after the line has gone high and fallen again.

// File: rtl/serial_rx_pkg.sv
// Package: shared constants and state encoding for the serial receiver.
// Assumes an 8-bit character container and a 2-bit length code offset by 5.
package serial_rx_pkg;
    localparam int OS_RATE   = 16;
    localparam int CHAR_W    = 8;
    localparam int MIN_BITS  = 5;
    localparam int LEN_W     = 2;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_START  = 3'd1,
        ST_DATA   = 3'd2,
        ST_PARITY = 3'd3,
        ST_STOP1  = 3'd4,
        ST_STOP2  = 3'd5
    } rx_state_t;
endpackage

// File: rtl/rx_line_sync.sv
// Module: rx_line_sync
// Brings the asynchronous line into the clock domain through a chain of
// flops and reports a one-cycle falling-edge strobe on the synced line.
// Assumes STAGES >= 2; all flops reset to the idle (high) level.
module rx_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic line_s,
    output logic line_fall
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    // Shift the raw line through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= {chain_q[STAGES-2:0], line_in};
    end

    // Remember the previous synced level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= chain_q[STAGES-1];
    end

    assign line_s    = chain_q[STAGES-1];
    assign line_fall = prev_q & ~chain_q[STAGES-1];
endmodule

// File: rtl/rx_tick_timer.sv
// Module: rx_tick_timer
// Counts oversampling ticks and strobes 'hit' on the tick that ends either
// a half bit (half_sel=1) or a full bit (half_sel=0). The count wraps to
// zero on each hit. 'restart' holds the count at zero.
// Assumes os_tick pulses are one clock wide.
module rx_tick_timer #(
    parameter int OS_RATE = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic os_tick,
    input  logic restart,
    input  logic half_sel,
    output logic hit
);
    localparam int CNT_W = $clog2(OS_RATE);
    localparam logic [CNT_W-1:0] HALF_END = CNT_W'(OS_RATE / 2 - 1);
    localparam logic [CNT_W-1:0] FULL_END = CNT_W'(OS_RATE - 1);

    logic [CNT_W-1:0] cnt_q;

    // Hit when the selected end count is reached on a tick.
    always_comb begin
        hit = os_tick && !restart && (cnt_q == (half_sel ? HALF_END : FULL_END));
    end

    // Advance the tick count; wrap on hit, clear on restart.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) cnt_q <= '0;
        else if (os_tick)      cnt_q <= hit ? '0 : cnt_q + 1'b1;
    end
endmodule

// File: rtl/rx_char_assembler.sv
// Module: rx_char_assembler
// Places each sampled data bit at its final position in a right-justified
// character. The position follows the arrival index, or is mirrored about
// the character length for MSB-first order. Keeps a running XOR for the
// parity check. 'clear' zeroes the character so unused upper bits read 0.
// Assumes the length code stays stable while bits are being collected.
module rx_char_assembler #(
    parameter int CHAR_W   = 8,
    parameter int MIN_BITS = 5,
    parameter int LEN_W    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              shift_en,
    input  logic              bit_in,
    input  logic [LEN_W-1:0]  len_code,
    input  logic              msb_first,
    output logic [CHAR_W-1:0] char_q,
    output logic              last_bit,
    output logic              parity_q
);
    localparam int IDX_W = $clog2(CHAR_W);

    logic [IDX_W-1:0] idx_q;
    logic [IDX_W-1:0] top_idx;
    logic [IDX_W-1:0] pos;

    // Highest bit index of the configured character length.
    always_comb begin
        top_idx  = IDX_W'(MIN_BITS - 1) + IDX_W'(len_code);
        pos      = msb_first ? (top_idx - idx_q) : idx_q;
        last_bit = (idx_q == top_idx);
    end

    // Store the arriving bit, advance the index and fold in parity.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            char_q   <= '0;
            idx_q    <= '0;
            parity_q <= 1'b0;
        end else if (shift_en) begin
            char_q[pos] <= bit_in;
            idx_q       <= idx_q + 1'b1;
            parity_q    <= parity_q ^ bit_in;
        end
    end
endmodule

// File: rtl/serial_frame_rx.sv
// Module: serial_frame_rx (top)
// Receives NRZ asynchronous frames: start bit, 5..8 data bits in either
// order, an optional even/odd parity bit, and 1 or 2 stop bits. Samples each
// bit at mid-point using a 16x tick. Reports a right-justified character with
// a one-cycle valid pulse at the last stop-bit sample, plus parity and framing
// flags that are held until the next pulse.
// Assumes configuration inputs are stable for the duration of a frame.
module serial_frame_rx
    import serial_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              os_tick,
    input  logic              rxd_in,
    input  logic [LEN_W-1:0]  cfg_len,
    input  logic              cfg_two_stop,
    input  logic              cfg_par_en,
    input  logic              cfg_par_odd,
    input  logic              cfg_msb_first,
    output logic [CHAR_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              rx_par_err,
    output logic              rx_frm_err
);
    rx_state_t         state_q;
    logic              line_s;
    logic              line_fall;
    logic              hit;
    logic              tmr_restart;
    logic              tmr_half;
    logic              asm_clear;
    logic              asm_shift;
    logic [CHAR_W-1:0] char_q;
    logic              last_bit;
    logic              parity_q;
    logic              par_bad_q;
    logic              stop_bad_q;

    rx_line_sync #(.STAGES(2)) i_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_in   (rxd_in),
        .line_s    (line_s),
        .line_fall (line_fall)
    );

    rx_tick_timer #(.OS_RATE(OS_RATE)) i_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .os_tick  (os_tick),
        .restart  (tmr_restart),
        .half_sel (tmr_half),
        .hit      (hit)
    );

    rx_char_assembler #(
        .CHAR_W   (CHAR_W),
        .MIN_BITS (MIN_BITS),
        .LEN_W    (LEN_W)
    ) i_asm (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (asm_clear),
        .shift_en  (asm_shift),
        .bit_in    (line_s),
        .len_code  (cfg_len),
        .msb_first (cfg_msb_first),
        .char_q    (char_q),
        .last_bit  (last_bit),
        .parity_q  (parity_q)
    );

    // Timer and assembler controls derived from the current state.
    always_comb begin
        tmr_restart = (state_q == ST_IDLE);
        tmr_half    = (state_q == ST_START);
        asm_clear   = (state_q == ST_START) && hit && !line_s;
        asm_shift   = (state_q == ST_DATA) && hit;
    end

    // Frame sequencing, error capture and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            par_bad_q  <= 1'b0;
            stop_bad_q <= 1'b0;
            rx_valid   <= 1'b0;
            rx_data    <= '0;
            rx_par_err <= 1'b0;
            rx_frm_err <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (line_fall) state_q <= ST_START;
                end
                ST_START: begin
                    if (hit) begin
                        par_bad_q  <= 1'b0;
                        stop_bad_q <= 1'b0;
                        state_q    <= line_s ? ST_IDLE : ST_DATA;
                    end
                end
                ST_DATA: begin
                    if (hit && last_bit)
                        state_q <= cfg_par_en ? ST_PARITY : ST_STOP1;
                end
                ST_PARITY: begin
                    if (hit) begin
                        par_bad_q <= (line_s != (parity_q ^ cfg_par_odd));
                        state_q   <= ST_STOP1;
                    end
                end
                ST_STOP1: begin
                    if (hit) begin
                        if (cfg_two_stop) begin
                            stop_bad_q <= !line_s;
                            state_q    <= ST_STOP2;
                        end else begin
                            rx_valid   <= 1'b1;
                            rx_data    <= char_q;
                            rx_par_err <= par_bad_q;
                            rx_frm_err <= !line_s;
                            state_q    <= ST_IDLE;
                        end
                    end
                end
                ST_STOP2: begin
                    if (hit) begin
                        rx_valid   <= 1'b1;
                        rx_data    <= char_q;
                        rx_par_err <= par_bad_q;
                        rx_frm_err <= stop_bad_q | !line_s;
                        state_q    <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/serial_frame_rx_chk.sv
// Module: serial_frame_rx_chk
// Property checker bound to serial_frame_rx. Observes ports only.
// Assumes configuration is held stable from a frame through its valid pulse.
module serial_frame_rx_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       os_tick,
    input logic       rxd_in,
    input logic [1:0] cfg_len,
    input logic       cfg_two_stop,
    input logic       cfg_par_en,
    input logic       cfg_par_odd,
    input logic       cfg_msb_first,
    input logic [7:0] rx_data,
    input logic       rx_valid,
    input logic       rx_par_err,
    input logic       rx_frm_err
);
    // R1
    reset_clears_chk: assert property (@(posedge clk)
        !rst_n |=> (!rx_valid && rx_data == 8'h00 && !rx_par_err && !rx_frm_err));

    // R8
    valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R8
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |-> ($stable(rx_data) && $stable(rx_par_err) && $stable(rx_frm_err)));

    // R3
    upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && cfg_len != 2'd3) |-> (rx_data[7] == 1'b0));

    // R3
    five_bit_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && cfg_len == 2'd0) |-> (rx_data[7:5] == 3'b000));

    // R6
    no_parity_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !cfg_par_en) |-> !rx_par_err);
endmodule

bind serial_frame_rx serial_frame_rx_chk i_chk (.*);

// File: tb/test_serial_frame_rx.sv
module test_serial_frame_rx;
    localparam int BIT_CLKS = 32;   // 16 ticks, one tick every 2 clocks
    localparam int NVEC     = 8;
    // {len[1:0], two_stop, par_en, par_odd, msb_first, bad_par, bad_stop, data[7:0]}
    localparam logic [15:0] VEC [NVEC] = '{
        16'hC0A5, 16'h00FF, 16'h742D, 16'h9C55,
        16'hD281, 16'h3D13, 16'hE401, 16'h937F
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       os_tick = 1'b0;
    logic       rxd_in = 1'b1;
    logic [1:0] cfg_len = 2'd3;
    logic       cfg_two_stop = 1'b0;
    logic       cfg_par_en = 1'b0;
    logic       cfg_par_odd = 1'b0;
    logic       cfg_msb_first = 1'b0;
    logic [7:0] rx_data;
    logic       rx_valid;
    logic       rx_par_err;
    logic       rx_frm_err;

    int total = 0;
    int bad = 0;
    int vcount = 0;
    int wide = 0;
    logic prev_valid = 1'b0;
    logic [7:0] cap_data = 8'h00;
    logic cap_perr = 1'b0;
    logic cap_ferr = 1'b0;

    always #10 clk = ~clk;

    serial_frame_rx i_serial_frame_rx (.*);

    // Tick generator: every second clock.
    always @(negedge clk) begin
        if (!rst_n) os_tick <= 1'b0;
        else        os_tick <= ~os_tick;
    end

    // Output monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (rx_valid) begin
            vcount++;
            cap_data = rx_data;
            cap_perr = rx_par_err;
            cap_ferr = rx_frm_err;
            if (prev_valid) wide++;
        end
        prev_valid = rx_valid;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic hold(input logic b);
        rxd_in = b;
        repeat (BIT_CLKS) @(negedge clk);
    endtask

    task automatic send_frame(input logic [1:0] len, input logic two, input logic pen,
                              input logic podd, input logic msb, input logic bpar,
                              input logic bstop, input logic [7:0] d);
        int n;
        logic [7:0] m;
        n = 5 + int'(len);
        m = 8'((1 << n) - 1);
        cfg_len = len; cfg_two_stop = two; cfg_par_en = pen;
        cfg_par_odd = podd; cfg_msb_first = msb;
        hold(1'b0);
        for (int i = 0; i < n; i++) hold(msb ? d[n-1-i] : d[i]);
        if (pen) hold((^(d & m)) ^ podd ^ bpar);
        if (two) hold(1'b1);
        hold(!bstop);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int expc;
        repeat (4) @(negedge clk);
        // R1: reset state
        chk("R1 valid", rx_valid, 0);
        chk("R1 data", rx_data, 0);
        chk("R1 flags", {rx_par_err, rx_frm_err}, 0);
        rst_n = 1'b1;
        repeat (40) @(negedge clk);

        expc = 0;
        for (int v = 0; v < NVEC; v++) begin
            logic [15:0] e;
            logic [7:0] m;
            string tg;
            e = VEC[v];
            m = 8'((1 << (5 + int'(e[15:14]))) - 1);
            send_frame(e[15:14], e[13], e[12], e[11], e[10], e[9], e[8], e[7:0]);
            hold(1'b1);
            expc++;
            tg = e[10] ? "R4" : "R3";
            chk("R8 count", vcount, expc);
            chk(tg, cap_data, e[7:0] & m);
            chk(e[12] ? "R5" : "R6", cap_perr, e[12] & e[9]);
            chk("R7", cap_ferr, e[8]);
            chk("R8 held", rx_data, e[7:0] & m);
        end

        // R2: short low glitch rejected
        rxd_in = 1'b0;
        repeat (6) @(negedge clk);
        rxd_in = 1'b1;
        repeat (200) @(negedge clk);
        chk("R2 glitch", vcount, expc);
        chk("R8 data held after glitch", rx_data, 8'h7F);

        // R9: stop bit low, line stays low
        send_frame(2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h3C);
        rxd_in = 1'b0;
        repeat (800) @(negedge clk);
        expc++;
        chk("R9 one pulse", vcount, expc);
        chk("R9 frm", cap_ferr, 1);
        hold(1'b1);
        send_frame(2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'hC6);
        hold(1'b1);
        expc++;
        chk("R9 recover count", vcount, expc);
        chk("R9 recover data", cap_data, 8'hC6);

        // R1: reset mid-frame
        cfg_len = 2'd3;
        hold(1'b0); hold(1'b1); hold(1'b0);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 mid-frame data", rx_data, 0);
        chk("R1 mid-frame valid", rx_valid, 0);
        rst_n = 1'b1;
        rxd_in = 1'b1;
        repeat (600) @(negedge clk);
        chk("R1 abandoned frame", vcount, expc);

        chk("R8 pulse width", wide, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule